// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, from the destination field of a received Ethernet frame, whether the frame is kept or dropped. The receive path feeds it one address bit per cycle on `bit_i`, qualified by `bit_vld_i`, after a `sof_i` pulse marks the frame start. Once the 48th bit has been taken in, the block reports its verdict on `accept_o` together with a one-cycle `decision_vld_o` strobe.

An address whose first received bit is 0 is an individual (station) address. It is compared bit by bit against the programmed `station_addr_i`. A group mode leaves the final four received bits out of that compare. An address whose first bit is 1 is a group (multicast or broadcast) address. It is accepted either unconditionally or through a 64-entry hash table. The hash index is taken from a CRC-32 computed over the 48 destination bits only.

The configuration inputs are expected to stay stable for the length of a frame. They are sampled in the cycle that carries the 48th bit.

Top module: `dest_addr_filter`

## Requirements
- R1: Out of reset `decision_vld_o` and `accept_o` are low, and address bits arriving before the first `sof_i` pulse are ignored and produce no decision.
- R2: Stream bit n (n = 0..47, counting only cycles with `bit_vld_i` high) corresponds to `station_addr_i[n]`. Address byte k therefore occupies bits 8k..8k+7 and is received least significant bit first. When stream bit 0 is 0, the frame is accepted exactly when all 48 bits equal the station address.
- R3: With `group_mode_i` high, stream bits 44..47 are left out of the station compare. Bits 0..43 must still match.
- R4: When stream bit 0 is 1 and `hash_en_i` is low, the frame is accepted if `mcast_all_i` is high and rejected if it is low.
- R5: The hash index is bits 5..0 of a CRC-32 with polynomial 0x04C11DB7. The CRC is preset to all ones at `sof_i`, then shifted once per address bit for the 48 address bits only, with no final inversion. Bit 0 is the register stage where incoming data is fed back.
- R6: When stream bit 0 is 1 and `hash_en_i` is high, the frame is accepted exactly when `hash_table_i[idx[2:0]*8 + idx[5:3]]` is 1. Index bits 2..0 select the byte and bits 5..3 select the bit in it. Hash filtering takes precedence over `mcast_all_i`.
- R7: `decision_vld_o` is high for exactly one cycle, in the cycle after the cycle that carries the 48th address bit. `accept_o` is high only while `decision_vld_o` is high.
- R8: Cycles with `bit_vld_i` low do not advance the address. Bits after the 48th are ignored until the next `sof_i` and produce no further decision.
- R9: `sof_i` discards any frame in progress and restarts address collection. A bit presented in the same cycle as `sof_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame pulse |
| bit_vld_i | input | 1 | Qualifies `bit_i` in this cycle |
| bit_i | input | 1 | Serial destination address bit |
| station_addr_i | input | 48 | Programmed station address, bit n = stream bit n |
| group_mode_i | input | 1 | Excludes the last four address bits from the station compare |
| mcast_all_i | input | 1 | Accept every group address when hashing is off |
| hash_en_i | input | 1 | Use the hash table for group addresses |
| hash_table_i | input | 64 | Multicast hash filter, 8 bytes of 8 bits |
| decision_vld_o | output | 1 | One-cycle strobe marking a decision |
| accept_o | output | 1 | Frame accepted (valid with `decision_vld_o`) |

## Verification
The assertions assume that `sof_i` is a single-cycle pulse that never overlaps a counted bit. They also assume that the configuration inputs do not change while a frame is being collected. The stimulus follows both rules: each frame starts with a lone `sof_i` cycle, and configuration changes only between frames. The one exception is the directed case that deliberately places a bit in the `sof_i` cycle. That case relies on the R9 drop rule rather than on the assumption. Random idle gaps and trailing bits beyond the 48th keep `bit_vld_i` irregular without breaking these rules.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
endpackage

// File: rtl/daf_bit_counter.sv
module daf_bit_counter #(
  parameter int ADDR_BITS = 48,
  localparam int CNT_W = $clog2(ADDR_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_i,
  input  logic             bit_vld_i,
  output logic             take_o,
  output logic             first_o,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(ADDR_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    take_o  = bit_vld_i && !sof_i && (cnt_q != DONE);
    first_o = take_o && (cnt_q == '0);
    last_o  = take_o && (cnt_q == LAST);
    cnt_d   = cnt_q;
    if (sof_i)       cnt_d = '0;
    else if (take_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= DONE;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DONE);                                            // R8
  AST_SOF_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> cnt_q == '0);                                    // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld_i && !sof_i) |=> $stable(cnt_q));                // R8
endmodule

// File: rtl/daf_crc_serial.sv
module daf_crc_serial
  import daf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             din_i,
  output logic [CRC_W-1:0] crc_nxt_o
);
  logic [CRC_W-1:0] crc_q, crc_d, shifted;
  logic             fb;

  always_comb begin
    fb        = crc_q[CRC_W-1] ^ din_i;
    shifted   = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    crc_nxt_o = shifted;
    crc_d     = crc_q;
    if (clear_i)   crc_d = CRC_INIT;
    else if (en_i) crc_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else        crc_q <= crc_d;
  end

  AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> crc_q == CRC_INIT);                            // R5
  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !en_i) |=> $stable(crc_q));                   // R5
endmodule

// File: rtl/daf_station_cmp.sv
module daf_station_cmp #(
  parameter int ADDR_BITS = 48,
  parameter int MASK_BITS = 4,
  localparam int CNT_W = $clog2(ADDR_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 en_i,
  input  logic                 din_i,
  input  logic [CNT_W-1:0]     pos_i,
  input  logic [ADDR_BITS-1:0] station_i,
  input  logic                 group_i,
  output logic                 mismatch_nxt_o
);
  localparam logic [CNT_W-1:0] MASK_FROM = CNT_W'(ADDR_BITS - MASK_BITS);

  logic mism_q, mism_d, masked, differs;

  always_comb begin
    masked         = group_i && (pos_i >= MASK_FROM);
    differs        = en_i && !masked && (din_i != station_i[pos_i]);
    mismatch_nxt_o = mism_q || differs;
    mism_d         = mism_q;
    if (clear_i)   mism_d = 1'b0;
    else if (en_i) mism_d = mismatch_nxt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mism_q <= 1'b0;
    else        mism_q <= mism_d;
  end

  AST_GROUP_TAIL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clear_i && group_i && pos_i >= MASK_FROM) |=> $stable(mism_q)); // R3
  AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mism_q && !clear_i) |=> mism_q);                          // R2
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int ADDR_BITS = 48,
  parameter int MASK_BITS = 4,
  parameter int IDX_W     = 6,
  localparam int TABLE_W  = 1 << IDX_W,
  localparam int LO_W     = IDX_W / 2,
  localparam int CNT_W    = $clog2(ADDR_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sof_i,
  input  logic                 bit_vld_i,
  input  logic                 bit_i,
  input  logic [ADDR_BITS-1:0] station_addr_i,
  input  logic                 group_mode_i,
  input  logic                 mcast_all_i,
  input  logic                 hash_en_i,
  input  logic [TABLE_W-1:0]   hash_table_i,
  output logic                 decision_vld_o,
  output logic                 accept_o
);
  logic             take, first, last;
  logic [CNT_W-1:0] cnt;
  logic [CRC_W-1:0] crc_nxt;
  logic             mism_nxt;
  logic             grp_q, grp_d, grp_now;
  logic [IDX_W-1:0] idx, tpos;
  logic             acc_d, dv_d, dv_q, acc_q;

  daf_bit_counter #(.ADDR_BITS(ADDR_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .bit_vld_i(bit_vld_i),
    .take_o(take), .first_o(first), .last_o(last), .cnt_o(cnt)
  );

  daf_crc_serial u_crc (
    .clk(clk), .rst_n(rst_n), .clear_i(sof_i), .en_i(take),
    .din_i(bit_i), .crc_nxt_o(crc_nxt)
  );

  daf_station_cmp #(.ADDR_BITS(ADDR_BITS), .MASK_BITS(MASK_BITS)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear_i(sof_i), .en_i(take), .din_i(bit_i),
    .pos_i(cnt), .station_i(station_addr_i), .group_i(group_mode_i),
    .mismatch_nxt_o(mism_nxt)
  );

  always_comb begin
    grp_now = first ? bit_i : grp_q;
    grp_d   = grp_q;
    if (sof_i)      grp_d = 1'b0;
    else if (first) grp_d = bit_i;
    idx  = crc_nxt[IDX_W-1:0];
    tpos = {idx[LO_W-1:0], idx[IDX_W-1:LO_W]};
    if (!grp_now)       acc_d = !mism_nxt;
    else if (hash_en_i) acc_d = hash_table_i[tpos];
    else                acc_d = mcast_all_i;
    dv_d = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= 1'b0;
      dv_q  <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      grp_q <= grp_d;
      dv_q  <= dv_d;
      acc_q <= dv_d && acc_d;
    end
  end

  assign decision_vld_o = dv_q;
  assign accept_o       = acc_q;

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dv_q |=> !dv_q);                                           // R7
  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> dv_q);                                           // R7
  AST_DECISION_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    dv_q |-> $past(bit_vld_i && !sof_i));                      // R7
  AST_SOF_NO_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> !dv_q);                                          // R9
  AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sof_i && take));                                         // R9
endmodule

// File: tb/dest_addr_filter_tb.sv
`timescale 1ns/1ps
module dest_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sof, vld, din;
  logic [47:0] sta;
  logic        grp, mall, hen;
  logic [63:0] tbl;
  logic        dv, acc;
  int          n_tests = 0;
  int          n_fail  = 0;
  int          cycles  = 0;

  always #2 clk = ~clk;

  dest_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .bit_vld_i(vld), .bit_i(din),
    .station_addr_i(sta), .group_mode_i(grp), .mcast_all_i(mall),
    .hash_en_i(hen), .hash_table_i(tbl), .decision_vld_o(dv), .accept_o(acc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Reflected CRC form, mapped back to the register orientation of R5
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    logic [5:0]  ix;
    for (int i = 0; i < 48; i++)
      r = (r >> 1) ^ (((r[0] ^ a[i]) != 1'b0) ? 32'hEDB8_8320 : 32'h0);
    for (int i = 0; i < 6; i++) ix[i] = r[31-i];
    return ix;
  endfunction

  function automatic bit ref_accept(input logic [47:0] a);
    logic [5:0]  ix;
    logic [47:0] m;
    if (!a[0]) begin
      m = grp ? 48'h0FFF_FFFF_FFFF : {48{1'b1}};
      return ((a ^ sta) & m) == '0;
    end
    if (hen) begin
      ix = ref_idx(a);
      return tbl[ix[2:0]*8 + ix[5:3]];
    end
    return mall;
  endfunction

  task automatic frame(input logic [47:0] a, input bit exp, input int extra,
                       input bit gaps, input string req);
    bit spur = 0;
    @(negedge clk); sof = 1; vld = 0;
    @(negedge clk); sof = 0;
    for (int i = 0; i < 48; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        vld = 0; @(negedge clk); spur |= dv;
      end
      vld = 1; din = a[i];
      @(negedge clk);
      if (i < 47) spur |= dv;
    end
    vld = 0;
    check(dv === 1'b1, {req, " R7 decision strobe"}, int'(dv), 1);
    check(acc === exp, {req, " verdict"}, int'(acc), int'(exp));
    for (int j = 0; j < extra; j++) begin
      vld = 1; din = 1'($urandom);
      @(negedge clk); spur |= dv;
    end
    vld = 0;
    @(negedge clk); spur |= dv;
    check(!spur, {req, " R7 R8 no extra strobe"}, int'(spur), 0);
  endtask

  initial begin
    logic [47:0] a;
    logic [5:0]  ix;
    bit          spur;
    void'($urandom(32'd1234));
    rst_n = 0; sof = 0; vld = 0; din = 0;
    sta = 48'h5634_1200_AB02; grp = 0; mall = 0; hen = 0; tbl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(dv === 1'b0 && acc === 1'b0, "R1 reset outputs", int'(dv), 0);

    // R1: bits before any sof are ignored
    spur = 0;
    for (int i = 0; i < 60; i++) begin
      vld = 1; din = sta[i % 48]; @(negedge clk); spur |= dv;
    end
    vld = 0; @(negedge clk); spur |= dv;
    check(!spur, "R1 no decision before sof", int'(spur), 0);

    // R2 station match and mismatches
    frame(sta, 1, 0, 0, "R2 exact match");
    frame(sta ^ 48'h8000_0000_0000, 0, 3, 1, "R2 last bit differs");
    frame(sta ^ 48'h0000_0100_0000, 0, 0, 1, "R2 middle bit differs");

    // R3 group mode
    grp = 1;
    frame(sta ^ 48'hF000_0000_0000, 1, 0, 0, "R3 tail masked");
    frame(sta ^ 48'h0800_0000_0000, 0, 0, 0, "R3 bit 43 still compared");
    grp = 0;

    // R4 group addresses without hashing
    a = 48'hFFFF_FFFF_FFFF;
    frame(a, 0, 0, 0, "R4 broadcast rejected");
    mall = 1;
    frame(a, 1, 0, 0, "R4 broadcast accept-all");

    // R5 R6 hash: only the addressed bit set, then all but it
    a = 48'h0000_5E00_0001 | 48'h1; hen = 1;
    ix = ref_idx(a);
    tbl = '0; tbl[ix[2:0]*8 + ix[5:3]] = 1'b1;
    frame(a, 1, 0, 1, "R5 R6 hash hit");
    tbl = ~tbl;
    frame(a, 0, 0, 1, "R6 hash miss overrides accept-all");
    mall = 0;

    // R9 restart mid-frame
    @(negedge clk); sof = 1; @(negedge clk); sof = 0;
    for (int i = 0; i < 20; i++) begin
      vld = 1; din = 1'($urandom); @(negedge clk);
    end
    vld = 0; hen = 0;
    frame(sta, 1, 2, 0, "R9 restart");

    // R9 bit in the sof cycle is dropped
    @(negedge clk); sof = 1; vld = 1; din = 1;
    @(negedge clk); sof = 0;
    spur = 0;
    for (int i = 0; i < 48; i++) begin
      din = sta[i]; @(negedge clk);
      if (i < 47) spur |= dv;
    end
    vld = 0;
    check(!spur && dv === 1'b1, "R9 sof-cycle bit dropped", int'(dv), 1);
    check(acc === 1'b1, "R9 sof-cycle frame verdict", int'(acc), 1);
    @(negedge clk);

    // random frames
    for (int k = 0; k < 60; k++) begin
      grp  = 1'($urandom); mall = 1'($urandom); hen = 1'($urandom);
      tbl  = {$urandom, $urandom};
      a    = {16'($urandom), $urandom};
      if ($urandom % 3 == 0) a = sta ^ (48'($urandom % 2) << ($urandom % 48));
      frame(a, ref_accept(a), $urandom % 4, 1, "R2 R3 R4 R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule